// File: doc/BRIEF.md
# Collision, Heartbeat and Loopback Steering for a Twisted-Pair Attachment Unit

This block is the control core of a 10 Mb/s twisted-pair attachment unit. A single status output tells the media access controller about two things: a collision and a heartbeat. A collision is raised while the local driver transmits and the receiver also reports a qualified signal. The heartbeat is a short pulse sent after every transmission to prove that the collision path works. The block also decides where the receive data path comes from and whether the line driver is on.

Two active-low mode selects control it. The full-duplex select keeps the receiver and driver running together and silences the status output. The loopback select turns the line driver off, feeds the controller's own transmit data and enable back into the receive outputs, and also silences the status output. When both selects are low, loopback wins. The block runs on the 10 MHz bit clock, so one clock equals one bit time. The receiver squelch and any serial test register are outside this block.

Top module: `csq_ctrl`

## Requirements
- R1: In normal mode (`fdx_n`=1, `loop_n`=1), when `tx_en` and `rx_valid_in` are both 1 at a rising clock edge, `col_stat` is 1 after that edge.
- R2: `col_stat` from a collision falls after the first rising edge at which `tx_en` or `rx_valid_in` is sampled 0. This is one clock, inside the two-clock limit.
- R3: In normal mode with `sqe_en_n`=0, a falling `tx_en` starts a heartbeat. The fall is first sampled 0 at edge E0. `col_stat` goes high after edge E0+`SQE_DELAY` and stays high for `SQE_LEN` clocks. The defaults are 8 and 10 bit times.
- R4: If `sqe_en_n` is 1 at the edge that samples the fall of `tx_en`, no heartbeat follows.
- R5: If `tx_en` is sampled 1 again while a heartbeat is waiting or pulsing, that heartbeat is dropped from the next edge on.
- R6: In full-duplex mode (`fdx_n`=0, `loop_n`=1), `col_stat` is 0 from the first edge that samples the mode, whatever `tx_en` and `rx_valid_in` do. No heartbeat is produced in this mode.
- R7: With `loop_n`=0, whatever `fdx_n` is, `rx_data_out` equals `tx_data`, `rx_valid_out` equals `tx_en` and `drv_en` is 0, all in the same cycle.
- R8: `col_stat` is 0 after every edge that samples `loop_n`=0. A heartbeat that is pending when loopback starts is dropped.
- R9: With `loop_n`=1, `rx_valid_out` follows `rx_valid_in`. `rx_data_out` equals `rx_data_in` while `rx_valid_in` is 1 and rests at 1 while it is 0. Both change in the same cycle when `REG_RX`=0.
- R10: While `rst_n` is 0, `col_stat` is 0.
- R11: With `loop_n`=1, `drv_en` equals `tx_en` in both normal and full-duplex mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz bit clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable from the controller |
| tx_data | input | 1 | Serial transmit data from the controller |
| rx_valid_in | input | 1 | Qualified (unsquelched) receive indication |
| rx_data_in | input | 1 | Serial data from the line receiver |
| sqe_en_n | input | 1 | Heartbeat enable, active low |
| fdx_n | input | 1 | Full-duplex select, active low |
| loop_n | input | 1 | Loopback select, active low |
| col_stat | output | 1 | Collision / heartbeat status to the controller |
| rx_data_out | output | 1 | Receive data to the controller |
| rx_valid_out | output | 1 | Receive-path-open indication to the controller |
| drv_en | output | 1 | Line driver enable |

## Verification
The hardest case to reach is a heartbeat cut off in mid-flight. It can be cut off by a new transmit enable, by a mode change into loopback, or by the enable input being withdrawn right at the falling edge. Each of these needs the stimulus to land inside a window that is only a few clocks wide. Directed sequences put the fall of `tx_en` at a known cycle. They then raise `tx_en` again, or pull `loop_n` low, a fixed number of clocks later, both during the wait phase and during the pulse. Random phases hold `tx_en` for long stretches and change modes rarely, so many falls lead to heartbeats that run their full course.

// File: rtl/csq_pkg.sv
package csq_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_FDX    = 2'd1,
      MODE_LOOP   = 2'd2
   } csq_mode_e;

   typedef enum logic [1:0] {
      HB_IDLE  = 2'd0,
      HB_WAIT  = 2'd1,
      HB_PULSE = 2'd2
   } csq_hb_e;

   // Loopback select outranks full duplex; both are active low.
   function automatic csq_mode_e csq_decode(input logic fdx_n, input logic loop_n);
      if (!loop_n)
         return MODE_LOOP;
      else if (!fdx_n)
         return MODE_FDX;
      else
         return MODE_NORMAL;
   endfunction

endpackage

// File: rtl/csq_col_det.sv
module csq_col_det
   import csq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  csq_mode_e mode_i,
   input  logic      tx_en_i,
   input  logic      rx_valid_i,
   output logic      col_o
);

   logic col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         col_q <= 1'b0;
      else
         col_q <= (mode_i == MODE_NORMAL) && tx_en_i && rx_valid_i;
   end

   assign col_o = col_q;

   // R2
   col_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!tx_en_i || !rx_valid_i) |-> !col_o);

   // R6
   col_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_i != MODE_NORMAL) |-> !col_o);

endmodule

// File: rtl/csq_sqe_gen.sv
module csq_sqe_gen
   import csq_pkg::*;
#(
   parameter int unsigned SQE_DELAY = 8,
   parameter int unsigned SQE_LEN   = 10
) (
   input  logic      clk,
   input  logic      rst_n,
   input  csq_mode_e mode_i,
   input  logic      tx_en_i,
   input  logic      sqe_en_n_i,
   output logic      pulse_o
);

   localparam int unsigned SPAN = (SQE_DELAY > SQE_LEN) ? SQE_DELAY : SQE_LEN;
   localparam int unsigned CW   = $clog2(SPAN + 1);
   localparam logic [CW-1:0] DLY_LAST = CW'(SQE_DELAY - 1);
   localparam logic [CW-1:0] LEN_LAST = CW'(SQE_LEN - 1);

   generate
      if (SQE_DELAY < 1 || SQE_LEN < 1) begin : g_bad_timing
         $error("csq_sqe_gen: SQE_DELAY and SQE_LEN must be at least 1");
      end
   endgenerate

   csq_hb_e       st_q;
   logic [CW-1:0] cnt_q;
   logic          tx_q;
   logic          fall;

   assign fall = tx_q && !tx_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= HB_IDLE;
         cnt_q <= '0;
         tx_q  <= 1'b0;
      end else begin
         tx_q <= tx_en_i;
         if (mode_i != MODE_NORMAL || tx_en_i) begin
            st_q  <= HB_IDLE;
            cnt_q <= '0;
         end else if (fall) begin
            st_q  <= sqe_en_n_i ? HB_IDLE : HB_WAIT;
            cnt_q <= '0;
         end else begin
            unique case (st_q)
               HB_WAIT: begin
                  if (cnt_q == DLY_LAST) begin
                     st_q  <= HB_PULSE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               HB_PULSE: begin
                  if (cnt_q == LEN_LAST) begin
                     st_q  <= HB_IDLE;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: cnt_q <= '0;
            endcase
         end
      end
   end

   assign pulse_o = (st_q == HB_PULSE);

   // R5
   hb_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> $past(!tx_en_i));

   // R4
   hb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_q && !tx_en_i && sqe_en_n_i) |=> (st_q == HB_IDLE));

   // R3
   hb_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HB_PULSE) |-> (cnt_q <= LEN_LAST));

endmodule

// File: rtl/csq_rx_path.sv
module csq_rx_path
   import csq_pkg::*;
#(
   parameter bit REG_RX = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  csq_mode_e mode_i,
   input  logic      tx_en_i,
   input  logic      tx_data_i,
   input  logic      rx_valid_i,
   input  logic      rx_data_i,
   output logic      rx_data_o,
   output logic      rx_valid_o,
   output logic      drv_en_o
);

   logic sel_data;
   logic sel_valid;

   always_comb begin
      if (mode_i == MODE_LOOP) begin
         sel_data  = tx_data_i;
         sel_valid = tx_en_i;
      end else begin
         sel_data  = rx_valid_i ? rx_data_i : 1'b1;
         sel_valid = rx_valid_i;
      end
   end

   assign drv_en_o = tx_en_i && (mode_i != MODE_LOOP);

   generate
      if (REG_RX) begin : g_reg
         logic data_q;
         logic valid_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q  <= 1'b1;
               valid_q <= 1'b0;
            end else begin
               data_q  <= sel_data;
               valid_q <= sel_valid;
            end
         end
         assign rx_data_o  = data_q;
         assign rx_valid_o = valid_q;
      end else begin : g_comb
         assign rx_data_o  = sel_data;
         assign rx_valid_o = sel_valid;

         // R9
         idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i != MODE_LOOP && !rx_valid_i) |-> rx_data_o);

         // R7
         loop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == MODE_LOOP) |-> (rx_data_o == tx_data_i && rx_valid_o == tx_en_i));
      end
   endgenerate

endmodule

// File: rtl/csq_ctrl.sv
module csq_ctrl
   import csq_pkg::*;
#(
   parameter int unsigned SQE_DELAY = 8,
   parameter int unsigned SQE_LEN   = 10,
   parameter bit          REG_RX    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_data,
   input  logic rx_valid_in,
   input  logic rx_data_in,
   input  logic sqe_en_n,
   input  logic fdx_n,
   input  logic loop_n,
   output logic col_stat,
   output logic rx_data_out,
   output logic rx_valid_out,
   output logic drv_en
);

   csq_mode_e mode;
   logic      col_hit;
   logic      hb_pulse;

   assign mode = csq_decode(fdx_n, loop_n);

   csq_col_det col_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode),
      .tx_en_i    (tx_en),
      .rx_valid_i (rx_valid_in),
      .col_o      (col_hit)
   );

   csq_sqe_gen #(
      .SQE_DELAY (SQE_DELAY),
      .SQE_LEN   (SQE_LEN)
   ) hb_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode),
      .tx_en_i    (tx_en),
      .sqe_en_n_i (sqe_en_n),
      .pulse_o    (hb_pulse)
   );

   csq_rx_path #(
      .REG_RX (REG_RX)
   ) rx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode),
      .tx_en_i    (tx_en),
      .tx_data_i  (tx_data),
      .rx_valid_i (rx_valid_in),
      .rx_data_i  (rx_data_in),
      .rx_data_o  (rx_data_out),
      .rx_valid_o (rx_valid_out),
      .drv_en_o   (drv_en)
   );

   assign col_stat = col_hit || hb_pulse;

   // R8
   loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!loop_n) |-> !col_stat);

   // R7
   loop_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_n |-> !drv_en);

   // R10
   always_comb begin
      if (!rst_n)
         reset_quiet_chk: assert (!col_stat);
   end

endmodule

// File: tb/csq_ctrl_tb.sv
module csq_ctrl_tb_top;

   localparam int D = 8;
   localparam int L = 10;
   localparam int WD_CYCLES = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 0, tx_data = 0, rx_valid_in = 0, rx_data_in = 0;
   logic sqe_en_n = 0, fdx_n = 1, loop_n = 1;
   logic col_stat, rx_data_out, rx_valid_out, drv_en;

   always #2 clk = ~clk;

   csq_ctrl #(.SQE_DELAY(D), .SQE_LEN(L), .REG_RX(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
      .rx_valid_in(rx_valid_in), .rx_data_in(rx_data_in), .sqe_en_n(sqe_en_n),
      .fdx_n(fdx_n), .loop_n(loop_n), .col_stat(col_stat),
      .rx_data_out(rx_data_out), .rx_valid_out(rx_valid_out), .drv_en(drv_en)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench-side expectation state
   bit m_col;
   int m_st;
   int m_cnt;
   bit m_txq;

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic void model_reset();
      m_col = 0; m_st = 0; m_cnt = 0; m_txq = 0;
   endfunction

   // one rising edge of the requirements' timing rules, using the sampled inputs
   function automatic void model_edge(bit te, bit rv, bit sqn, bit fn, bit ln);
      bit normal = ln && fn;
      m_col = normal && te && rv;
      if (!normal || te) begin
         m_st = 0; m_cnt = 0;
      end else if (m_txq && !te) begin
         m_st = sqn ? 0 : 1; m_cnt = 0;
      end else if (m_st == 1) begin
         if (m_cnt == D - 1) begin m_st = 2; m_cnt = 0; end
         else m_cnt++;
      end else if (m_st == 2) begin
         if (m_cnt == L - 1) begin m_st = 0; m_cnt = 0; end
         else m_cnt++;
      end
      m_txq = te;
   endfunction

   function automatic bit exp_col();
      return m_col || (m_st == 2);
   endfunction

   // advance one cycle: edge sampled the old inputs, then apply new ones and compare
   task automatic cyc(input bit te, input bit td, input bit rv, input bit rd,
                      input bit sqn, input bit fn, input bit ln);
      @(negedge clk);
      if (rst_n) model_edge(tx_en, rx_valid_in, sqe_en_n, fdx_n, loop_n);
      else model_reset();
      tx_en = te; tx_data = td; rx_valid_in = rv; rx_data_in = rd;
      sqe_en_n = sqn; fdx_n = fn; loop_n = ln;
      #1;
      check("R1 R3 R6 R8 col_stat", col_stat, exp_col());
      if (!ln) begin
         check("R7 rx_data_out", rx_data_out, td);
         check("R7 rx_valid_out", rx_valid_out, te);
         check("R7 drv_en", drv_en, 1'b0);
      end else begin
         check("R9 rx_data_out", rx_data_out, rv ? rd : 1'b1);
         check("R9 rx_valid_out", rx_valid_out, rv);
         check("R11 drv_en", drv_en, te);
      end
   endtask

   initial begin
      #(4 * WD_CYCLES);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int first, len;
      bit saw;
      void'($urandom(32'h5eed_c0de));
      model_reset();
      // R10 reset state
      repeat (3) cyc(1, 0, 1, 0, 0, 1, 1);
      check("R10 col_stat in reset", col_stat, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      cyc(0, 0, 0, 0, 0, 1, 1);

      // R1 collision, R2 drop via rx_valid
      cyc(1, 1, 1, 0, 0, 1, 1);
      cyc(1, 1, 1, 0, 0, 1, 1);
      check("R1 collision raised", col_stat, 1'b1);
      cyc(1, 0, 0, 0, 0, 1, 1);
      cyc(1, 0, 0, 0, 0, 1, 1);
      check("R2 collision ends after rx_valid drop", col_stat, 1'b0);

      // R3 heartbeat timing measured from the fall of tx_en
      cyc(0, 0, 0, 0, 0, 1, 1);
      first = -1; len = 0;
      for (int k = 1; k <= D + L + 4; k++) begin
         cyc(0, 0, 0, 0, 0, 1, 1);
         if (col_stat) begin
            if (first < 0) first = k;
            len++;
         end
      end
      check("R3 heartbeat start cycle", first == D + 1, 1'b1);
      check("R3 heartbeat length", len == L, 1'b1);

      // R4 heartbeat gated off
      cyc(1, 0, 0, 0, 1, 1, 1);
      cyc(0, 0, 0, 0, 1, 1, 1);
      saw = 0;
      for (int k = 0; k < D + L + 2; k++) begin
         cyc(0, 0, 0, 0, 0, 1, 1);
         saw |= col_stat;
      end
      check("R4 no heartbeat when disabled", saw, 1'b0);

      // R5 cancel in wait phase and in pulse phase
      cyc(1, 0, 0, 0, 0, 1, 1);
      cyc(0, 0, 0, 0, 0, 1, 1);
      repeat (3) cyc(0, 0, 0, 0, 0, 1, 1);
      cyc(1, 0, 0, 0, 0, 1, 1);
      saw = 0;
      for (int k = 0; k < D + L + 2; k++) begin
         cyc(1, 0, 0, 0, 0, 1, 1);
         saw |= col_stat;
      end
      check("R5 heartbeat cancelled in wait", saw, 1'b0);
      cyc(0, 0, 0, 0, 0, 1, 1);
      repeat (D + 2) cyc(0, 0, 0, 0, 0, 1, 1);
      check("R5 heartbeat running", col_stat, 1'b1);
      cyc(1, 0, 0, 0, 0, 1, 1);
      cyc(1, 0, 0, 0, 0, 1, 1);
      check("R5 heartbeat cancelled in pulse", col_stat, 1'b0);

      // R6 full duplex: no collision, no heartbeat
      saw = 0;
      for (int k = 0; k < 6; k++) begin
         cyc(1, k[0], 1, k[1], 0, 0, 1);
         saw |= col_stat;
      end
      cyc(0, 0, 1, 1, 0, 0, 1);
      for (int k = 0; k < D + L + 2; k++) begin
         cyc(0, 0, 0, 0, 0, 0, 1);
         saw |= col_stat;
      end
      check("R6 full duplex silent", saw, 1'b0);

      // R8 loopback cancels a pending heartbeat, and R7 with both selects low
      cyc(1, 0, 0, 0, 0, 1, 1);
      cyc(0, 0, 0, 0, 0, 1, 1);
      repeat (D + 2) cyc(0, 0, 0, 0, 0, 1, 1);
      check("R8 heartbeat before loopback", col_stat, 1'b1);
      cyc(0, 1, 0, 0, 0, 0, 0);
      cyc(1, 0, 1, 1, 0, 0, 0);
      check("R8 loopback silences status", col_stat, 1'b0);
      check("R7 loop priority data", rx_data_out, 1'b0);
      cyc(1, 1, 1, 0, 0, 1, 0);
      check("R7 loop valid follows tx_en", rx_valid_out, 1'b1);
      cyc(0, 0, 0, 0, 0, 1, 1);
      repeat (D + L + 3) cyc(0, 0, 0, 0, 0, 1, 1);

      // random phase
      begin
         bit te = 0, rv = 0, sqn = 0, fn = 1, ln = 1;
         for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(15) == 0) te = ~te;
            if ($urandom_range(7) == 0) rv = ~rv;
            if ($urandom_range(150) == 0) sqn = ~sqn;
            if ($urandom_range(300) == 0) fn = ~fn;
            if ($urandom_range(400) == 0) ln = ~ln;
            cyc(te, 1'($urandom), rv, 1'($urandom), sqn, fn, ln);
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule